// File: doc/BRIEF.md
# Early Branch Resolver for the Decode Stage

This block settles conditional branches one stage after fetch, while the branch sits in the decode/register-read stage, so that a taken branch costs one fetch slot rather than three. It owns the fetch program counter and the fetch-to-decode pipeline register. In decode it tests the source register against zero and adds the scaled, sign-extended offset to the branch's sequential address. It then picks the address of the next fetch.

A mode input selects the policy for the instruction fetched right behind a branch. In squash mode, fetch always runs ahead sequentially. If the branch turns out taken, that successor is replaced by a no-op on the same clock edge that loads the target into the program counter. In delay-slot mode, the successor always proceeds into decode untouched, whatever the outcome. The register file read itself is outside the block: the block exports the source register index and takes back its value in the same cycle.

Top module: `br_resolve_unit`

## Requirements
- R1: While reset is asserted and just after it: fetch_pc equals RESET_PC (default 0), dec_instr holds the no-op word 32'h0000_0000, dec_pc4 is 0, and br_take and br_flush are low.
- R2: With no taken branch in decode, next_pc equals fetch_pc + 4, and fetch_pc advances by 4 on every clock edge.
- R3: The opcode is in instruction bits 31:26. Opcode 6'h04 (branch if zero) is taken exactly when rs_value is zero. Opcode 6'h05 (branch if non-zero) is taken exactly when rs_value is non-zero.
- R4: For a taken branch, next_pc equals dec_pc4 plus the 16-bit immediate in bits 15:0, sign-extended and shifted left by 2. This holds for negative offsets too.
- R5: When delay_mode is 0 and a branch is taken, br_flush is high. On the next edge dec_instr becomes the no-op word, and fetch_pc becomes the target.
- R6: When delay_mode is 1, br_flush stays low. The instruction fetched behind the branch enters dec_instr unchanged, whether the branch is taken or not.
- R7: A branch that is not taken leaves br_flush low and lets fetch continue at fetch_pc + 4.
- R8: rs_idx always equals dec_instr bits 25:21.
- R9: An opcode other than 6'h04 or 6'h05 never raises br_take, whatever rs_value holds.
- R10: On every edge, dec_pc4 is loaded with fetch_pc + 4 of the instruction entering decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| delay_mode | input | 1 | 0 = squash the successor of a taken branch, 1 = one delay slot |
| fetch_instr | input | 32 | Instruction word read at fetch_pc |
| rs_value | input | XLEN | Register file value for rs_idx |
| fetch_pc | output | XLEN | Current fetch address |
| rs_idx | output | 5 | Source register index of the decode instruction |
| dec_instr | output | 32 | Instruction held in the decode stage |
| dec_pc4 | output | XLEN | Sequential address that follows the decode instruction |
| br_take | output | 1 | Decode-stage branch resolved taken |
| br_flush | output | 1 | Successor is being squashed this edge |
| next_pc | output | XLEN | Address loaded into fetch_pc on the next edge |

## Verification
Each branch opcode is driven with a zero value and with non-zero values that have only the top bit, only a middle bit, or all bits set. This separates a full-width zero test from a partial one and keeps the two conditions apart. Offsets are positive, negative and at both extremes of the 16-bit range, which exposes a missing sign extension or a missing shift. The same taken and not-taken cases are run under both modes, so that a squash appearing in delay-slot mode, or missing in squash mode, shows up in dec_instr. Non-branch opcodes with a zero register confirm that only the two branch codes decode as branches.

// File: rtl/br_resolve_pkg.sv
package br_resolve_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned OPC_W   = 6;
    localparam int unsigned REG_W   = 5;
    localparam int unsigned IMM_W   = 16;
    localparam int unsigned OPC_LSB = 26;
    localparam int unsigned RS_LSB  = 21;
    localparam int unsigned WORD_SH = 2;

    localparam logic [OPC_W-1:0]   OPC_BR_ZERO    = 6'h04;
    localparam logic [OPC_W-1:0]   OPC_BR_NONZERO = 6'h05;
    localparam logic [INSTR_W-1:0] NOP_WORD       = '0;

    typedef enum logic [1:0] {
        BK_NONE    = 2'd0,
        BK_ZERO    = 2'd1,
        BK_NONZERO = 2'd2
    } br_kind_e;

    function automatic br_kind_e classify(input logic [INSTR_W-1:0] instr);
        logic [OPC_W-1:0] opc;
        opc = instr[OPC_LSB +: OPC_W];
        if (opc == OPC_BR_ZERO)         return BK_ZERO;
        else if (opc == OPC_BR_NONZERO) return BK_NONZERO;
        else                            return BK_NONE;
    endfunction

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_resolve_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  br_kind_e          kind,
    input  logic [XLEN-1:0]   value,
    output logic              taken
);

    logic is_zero;

    always_comb begin
        is_zero = (value == '0);
        unique case (kind)
            BK_ZERO:    taken = is_zero;
            BK_NONZERO: taken = !is_zero;
            default:    taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/br_target_add.sv
module br_target_add
    import br_resolve_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OFF_W = IMM_W,
    parameter int unsigned SHIFT = WORD_SH
) (
    input  logic [XLEN-1:0]  base,
    input  logic [OFF_W-1:0] offset,
    output logic [XLEN-1:0]  target
);

    localparam int unsigned EXT_W = XLEN - OFF_W - SHIFT;

    logic [XLEN-1:0] scaled;

    generate
        if (SHIFT > 0) begin : g_shift
            assign scaled = {{EXT_W{offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
        end else begin : g_noshift
            assign scaled = {{EXT_W{offset[OFF_W-1]}}, offset};
        end
    endgenerate

    assign target = base + scaled;

endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
    import br_resolve_pkg::*;
#(
    parameter int unsigned     XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                delay_mode,
    input  logic [INSTR_W-1:0]  fetch_instr,
    input  logic [XLEN-1:0]     rs_value,
    output logic [XLEN-1:0]     fetch_pc,
    output logic [REG_W-1:0]    rs_idx,
    output logic [INSTR_W-1:0]  dec_instr,
    output logic [XLEN-1:0]     dec_pc4,
    output logic                br_take,
    output logic                br_flush,
    output logic [XLEN-1:0]     next_pc
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    typedef struct packed {
        logic [XLEN-1:0]    pc;
        logic [INSTR_W-1:0] instr;
        logic [XLEN-1:0]    pc4;
    } front_t;

    front_t   st_d, st_q;
    br_kind_e kind;
    logic     cond_taken;
    logic [XLEN-1:0] tgt;
    logic [XLEN-1:0] seq_pc;

    assign kind = classify(st_q.instr);

    br_cond_eval #(.XLEN(XLEN)) u_cond (
        .kind  (kind),
        .value (rs_value),
        .taken (cond_taken)
    );

    br_target_add #(.XLEN(XLEN), .OFF_W(IMM_W), .SHIFT(WORD_SH)) u_tgt (
        .base   (st_q.pc4),
        .offset (st_q.instr[IMM_W-1:0]),
        .target (tgt)
    );

    always_comb begin
        seq_pc   = st_q.pc + STEP;
        br_take  = cond_taken;
        br_flush = cond_taken && !delay_mode;
        next_pc  = cond_taken ? tgt : seq_pc;

        st_d       = st_q;
        st_d.pc    = next_pc;
        st_d.pc4   = seq_pc;
        st_d.instr = br_flush ? NOP_WORD : fetch_instr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc    <= RESET_PC;
            st_q.instr <= NOP_WORD;
            st_q.pc4   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc  = st_q.pc;
    assign dec_instr = st_q.instr;
    assign dec_pc4   = st_q.pc4;
    assign rs_idx    = st_q.instr[RS_LSB +: REG_W];

endmodule

// File: rtl/br_resolve_checker.sv
module br_resolve_checker
    import br_resolve_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               delay_mode,
    input logic [XLEN-1:0]    rs_value,
    input logic [XLEN-1:0]    fetch_pc,
    input logic [INSTR_W-1:0] dec_instr,
    input logic [XLEN-1:0]    dec_pc4,
    input logic               br_take,
    input logic               br_flush,
    input logic [XLEN-1:0]    next_pc
);

    logic [OPC_W-1:0] opc;
    assign opc = dec_instr[OPC_LSB +: OPC_W];

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !br_take |-> next_pc == fetch_pc + XLEN'(4));

    p_pc_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> fetch_pc == $past(next_pc));

    p_zero_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_BR_ZERO) |-> br_take == (rs_value == '0));

    p_nonzero_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_BR_NONZERO) |-> br_take == (rs_value != '0));

    p_squash_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        br_flush |=> dec_instr == NOP_WORD);

    p_squash_needs_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        br_flush |-> br_take);

    p_delay_no_squash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        delay_mode |-> !br_flush);

    p_non_branch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != OPC_BR_ZERO && opc != OPC_BR_NONZERO) |-> !br_take);

    p_pc4_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> dec_pc4 == $past(fetch_pc) + XLEN'(4));

endmodule

bind br_resolve_unit br_resolve_checker #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .delay_mode (delay_mode),
    .rs_value   (rs_value),
    .fetch_pc   (fetch_pc),
    .dec_instr  (dec_instr),
    .dec_pc4    (dec_pc4),
    .br_take    (br_take),
    .br_flush   (br_flush),
    .next_pc    (next_pc)
);

// File: tb/br_resolve_unit_bench.sv
module br_resolve_unit_bench;

    localparam int XLEN = 32;
    localparam int NVEC = 10;
    localparam logic [31:0] FILL = 32'h0123_4567;

    // vector: {delay_mode, opcode[5:0], rs_value[31:0], imm[15:0], exp_take}
    localparam logic [55:0] VECS [NVEC] = '{
        {1'b0, 6'h04, 32'h0000_0000, 16'h0010, 1'b1},
        {1'b0, 6'h04, 32'h0000_0005, 16'h0010, 1'b0},
        {1'b0, 6'h05, 32'hFFFF_FFFF, 16'hFFF8, 1'b1},
        {1'b0, 6'h05, 32'h0000_0000, 16'hFFF8, 1'b0},
        {1'b1, 6'h04, 32'h0000_0000, 16'hFFFC, 1'b1},
        {1'b1, 6'h05, 32'h0000_0001, 16'h0003, 1'b1},
        {1'b1, 6'h04, 32'h8000_0000, 16'h8000, 1'b0},
        {1'b0, 6'h06, 32'h0000_0000, 16'h0020, 1'b0},
        {1'b0, 6'h05, 32'h0001_0000, 16'h7FFF, 1'b1},
        {1'b1, 6'h00, 32'h0000_0000, 16'h0040, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             delay_mode = 1'b0;
    logic [31:0]      fetch_instr = 32'h0;
    logic [XLEN-1:0]  rs_value = '0;
    logic [XLEN-1:0]  fetch_pc;
    logic [4:0]       rs_idx;
    logic [31:0]      dec_instr;
    logic [XLEN-1:0]  dec_pc4;
    logic             br_take;
    logic             br_flush;
    logic [XLEN-1:0]  next_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    br_resolve_unit u_br_resolve_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .delay_mode  (delay_mode),
        .fetch_instr (fetch_instr),
        .rs_value    (rs_value),
        .fetch_pc    (fetch_pc),
        .rs_idx      (rs_idx),
        .dec_instr   (dec_instr),
        .dec_pc4     (dec_pc4),
        .br_take     (br_take),
        .br_flush    (br_flush),
        .next_pc     (next_pc)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pc_at_fetch, instr, tgt, exp_next;
        logic mode, exp_take, exp_flush;
        logic [5:0] opc;
        logic [31:0] val;
        logic [15:0] imm;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 fetch_pc", fetch_pc, 32'h0);
        check("R1 dec_instr", dec_instr, 32'h0);
        check("R1 dec_pc4", dec_pc4, 32'h0);
        check("R1 take/flush", {30'h0, br_take, br_flush}, 32'h0);
        rst_n = 1'b1;

        // R2: sequential advance with no-op in decode
        @(negedge clk);
        check("R2 first step", fetch_pc, 32'h4);
        check("R2 next_pc", next_pc, 32'h8);
        @(negedge clk);
        check("R2 second step", fetch_pc, 32'h8);
        check("R10 dec_pc4", dec_pc4, 32'h8);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            {mode, opc, val, imm, exp_take} = VECS[i];
            exp_flush = exp_take && !mode;
            instr = {opc, 5'd9 + 5'(i), 5'd0, imm};
            @(negedge clk);
            delay_mode  = mode;
            rs_value    = 32'h0;
            pc_at_fetch = fetch_pc;
            fetch_instr = instr;
            @(negedge clk);
            rs_value    = val;
            fetch_instr = FILL;
            #1;
            tgt = pc_at_fetch + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
            exp_next = exp_take ? tgt : pc_at_fetch + 32'd8;
            check($sformatf("R3/R9 take v%0d", i), {31'h0, br_take}, {31'h0, exp_take});
            check($sformatf("R5/R6/R7 flush v%0d", i), {31'h0, br_flush}, {31'h0, exp_flush});
            check($sformatf("R4/R7 next_pc v%0d", i), next_pc, exp_next);
            check($sformatf("R8 rs_idx v%0d", i), {27'h0, rs_idx}, {27'h0, instr[25:21]});
            check($sformatf("R10 dec_pc4 v%0d", i), dec_pc4, pc_at_fetch + 32'd4);
            @(negedge clk);
            check($sformatf("R5/R6 dec_instr v%0d", i), dec_instr, exp_flush ? 32'h0 : FILL);
            check($sformatf("R4/R2 fetch_pc v%0d", i), fetch_pc, exp_next);
        end

        // R9: non-branch with non-zero register too
        @(negedge clk);
        delay_mode  = 1'b0;
        fetch_instr = {6'h07, 5'd1, 5'd0, 16'h0010};
        @(negedge clk);
        rs_value = 32'h1;
        fetch_instr = FILL;
        #1;
        check("R9 opcode 07", {31'h0, br_take}, 32'h0);

        // R1: reset mid-run restores state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset pc", fetch_pc, 32'h0);
        check("R1 re-reset instr", dec_instr, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule